// File: doc/BRIEF.md
# Debug Register Scan Chain Access

This block is a small debug register file that a debugger reaches only through a serial data register. The chain is 38 bits long. It is shifted least significant bit first from `tdi` to `tdo`. The TAP state machine is not part of the block: it appears as three single-cycle strobes for capture, shift and update. Each scan carries a data word, a register address and a direction flag.

A write scan stores its data word into the addressed register when the update strobe arrives. A read scan only records the address at update. The value of that register is then loaded into the chain at the capture of the next scan. Reading therefore costs two scans. The follow-up scan should point at a register whose read has no side effect.

The register map covers the following:
- a debug control register, whose monitor-mode bit drives an output;
- a debug status register, which reflects a core-side input;
- a vector catch register;
- a communications channel made of a control register and a data register. Reading the data register consumes its contents.
- two watchpoint register sets. The comparators behind these registers lie outside this block.

Top module: `dbg_scan_regs`

## Requirements
- R1: The chain is 38 bits wide. Data sits in bits 31:0, the register address in bits 36:32, and the direction flag in bit 37. Each shift strobe moves `tdi` into bit 37 and every bit one place toward bit 0. `tdo` always shows bit 0, so the first bit shifted out is bit 0.
- R2: On update, a scan with bit 37 = 1 writes bits 31:0 into the register named by bits 36:32. Only the low bits a register implements are kept.
- R3: On update, a scan with bit 37 = 0 writes nothing and ignores its data bits. It records its address as the pending read. At the capture of the next scan, bits 31:0 load that register's value and bits 37:32 load zero.
- R4: A capture with no pending read loads zero. There is no pending read after reset or after any write scan.
- R5: Address 0 is debug control (6 bits), address 2 is vector catch (8 bits) and address 5 is comms data (32 bits). Registers narrower than 32 bits read back with their upper bits zero.
- R6: Address 1 reads the 5-bit `status_in` input. Writes to address 1 have no effect.
- R7: `mon_mode` equals bit 4 of debug control.
- R8: Watchpoint set 0 occupies addresses 8 to 13 and set 1 occupies addresses 16 to 21. Offsets 0 to 3 are 32-bit registers, offset 4 is 9 bits and offset 5 is 8 bits.
- R9: Every other address (3, 6, 7, 14, 15 and 22 to 31) reads as zero and ignores writes.
- R10: Address 4 is comms control (6 bits). Bits 5:1 are writable. Bit 0 is a data-full flag: a write to comms data sets it, and a capture that reads comms data clears it. Capturing comms control clears nothing. Comms data keeps its value after it is read.
- R11: A synchronous reset clears every register, the pending read, the full flag and the chain, so `mon_mode` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tdi | input | 1 | Serial data into the chain |
| capture_en | input | 1 | Capture strobe: loads the pending read value into the chain |
| shift_en | input | 1 | Shift strobe: moves the chain one bit toward `tdo` |
| update_en | input | 1 | Update strobe: performs the write or records the read address |
| status_in | input | 5 | Core status, returned by reads of address 1 |
| tdo | output | 1 | Serial data out of the chain (bit 0) |
| mon_mode | output | 1 | Monitor-mode enable from debug control |

## Verification
The assertions assume that at most one of the capture, shift and update strobes is high in any cycle. This matches a TAP controller, which is only ever in one of those states, and one assertion states the assumption directly. The bench drives every scan through a single task. That task raises capture for one cycle, then shift for exactly 38 cycles, then update for one cycle, with all strobes low in between, so the strobes never overlap and no scan is partial. The expected capture of each scan is queued before the scan starts. It follows the two-scan read rule, including the side effect of reading comms data.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int CHAIN_W  = DATA_W + ADDR_W + 1;
    localparam int DIR_BIT  = DATA_W + ADDR_W;

    localparam int CTRL_W   = 6;
    localparam int STAT_W   = 5;
    localparam int VCATCH_W = 8;
    localparam int CCTRL_W  = 6;
    localparam int MON_BIT  = 4;

    localparam int NUM_WP    = 2;
    localparam int WP_SLOTS  = 6;
    localparam int WP_CVAL_W = 9;
    localparam int WP_CMSK_W = 8;
    localparam int SLOT_W    = 3;
    localparam int WIN_W     = ADDR_W - SLOT_W;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'd1;
    localparam logic [ADDR_W-1:0] A_VCATCH = 5'd2;
    localparam logic [ADDR_W-1:0] A_CCTRL  = 5'd4;
    localparam logic [ADDR_W-1:0] A_CDATA  = 5'd5;

    typedef struct packed {
        logic                  pend_valid;
        logic [ADDR_W-1:0]     pend_addr;
        logic [CTRL_W-1:0]     ctrl;
        logic [VCATCH_W-1:0]   vcatch;
        logic [CCTRL_W-1:1]    ccfg;
        logic                  cfull;
        logic [DATA_W-1:0]     cdata;
    } core_state_t;
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter #(
    parameter int W = 38
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tdi,
    input  logic         capture_en,
    input  logic         shift_en,
    input  logic [W-1:0] cap_word,
    output logic [W-1:0] chain_q,
    output logic         tdo
);
    logic [W-1:0] chain_d;

    always_comb begin
        chain_d = chain_q;
        if (capture_en) begin
            chain_d = cap_word;
        end else if (shift_en) begin
            chain_d = {tdi, chain_q[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign tdo = chain_q[0];

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!capture_en && !shift_en) |=> $stable(chain_q)); // R1
endmodule

// File: rtl/dbg_watch_set.sv
module dbg_watch_set #(
    parameter int DW     = 32,
    parameter int CVW    = 9,
    parameter int CMW    = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DW-1:0]     wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DW-1:0]     rd_data
);
    typedef struct packed {
        logic [DW-1:0]  avl;
        logic [DW-1:0]  amk;
        logic [DW-1:0]  dvl;
        logic [DW-1:0]  dmk;
        logic [CVW-1:0] cvl;
        logic [CMW-1:0] cmk;
    } wp_state_t;

    wp_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_slot)
                3'd0:    s_d.avl = wr_data;
                3'd1:    s_d.amk = wr_data;
                3'd2:    s_d.dvl = wr_data;
                3'd3:    s_d.dmk = wr_data;
                3'd4:    s_d.cvl = wr_data[CVW-1:0];
                3'd5:    s_d.cmk = wr_data[CMW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        case (rd_slot)
            3'd0:    rd_data = s_q.avl;
            3'd1:    rd_data = s_q.amk;
            3'd2:    rd_data = s_q.dvl;
            3'd3:    rd_data = s_q.dmk;
            3'd4:    rd_data = {{(DW-CVW){1'b0}}, s_q.cvl};
            3'd5:    rd_data = {{(DW-CMW){1'b0}}, s_q.cmk};
            default: rd_data = '0;
        endcase
    end

    AST_WP_CMASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_slot == 3'd5) |=> (rd_slot != 3'd5 || rd_data[DW-1:CMW] == '0)); // R8
    AST_WP_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(s_q)); // R9
endmodule

// File: rtl/dbg_scan_regs.sv
module dbg_scan_regs
    import dbg_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tdi,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic [STAT_W-1:0] status_in,
    output logic              tdo,
    output logic              mon_mode
);
    core_state_t s_d, s_q;

    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] cap_word;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  wr_data;
    logic [ADDR_W-1:0]  wr_addr;
    logic               upd_wr;
    logic               upd_rd;
    logic [DATA_W-1:0]  wp_raw [NUM_WP];
    logic [DATA_W-1:0]  wp_rd  [NUM_WP];
    logic [DATA_W-1:0]  wp_any;

    assign wr_data = chain_q[DATA_W-1:0];
    assign wr_addr = chain_q[DIR_BIT-1:DATA_W];
    assign upd_wr  = update_en &&  chain_q[DIR_BIT];
    assign upd_rd  = update_en && !chain_q[DIR_BIT];

    dbg_scan_shifter #(.W(CHAIN_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .tdi        (tdi),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .cap_word   (cap_word),
        .chain_q    (chain_q),
        .tdo        (tdo)
    );

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        localparam logic [WIN_W-1:0] WIN = WIN_W'(g + 1);
        logic wr_hit;
        assign wr_hit = upd_wr && (wr_addr[ADDR_W-1:SLOT_W] == WIN)
                        && (wr_addr[SLOT_W-1:0] < SLOT_W'(WP_SLOTS));
        dbg_watch_set #(
            .DW     (DATA_W),
            .CVW    (WP_CVAL_W),
            .CMW    (WP_CMSK_W),
            .SLOT_W (SLOT_W)
        ) u_set (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_hit),
            .wr_slot (wr_addr[SLOT_W-1:0]),
            .wr_data (wr_data),
            .rd_slot (s_q.pend_addr[SLOT_W-1:0]),
            .rd_data (wp_raw[g])
        );
        assign wp_rd[g] = (s_q.pend_addr[ADDR_W-1:SLOT_W] == WIN) ? wp_raw[g] : '0;
    end

    always_comb begin
        wp_any = '0;
        for (int i = 0; i < NUM_WP; i++) wp_any = wp_any | wp_rd[i];
    end

    always_comb begin
        rd_word = '0;
        if (s_q.pend_valid) begin
            case (s_q.pend_addr)
                A_CTRL:   rd_word = {{(DATA_W-CTRL_W){1'b0}}, s_q.ctrl};
                A_STAT:   rd_word = {{(DATA_W-STAT_W){1'b0}}, status_in};
                A_VCATCH: rd_word = {{(DATA_W-VCATCH_W){1'b0}}, s_q.vcatch};
                A_CCTRL:  rd_word = {{(DATA_W-CCTRL_W){1'b0}}, s_q.ccfg, s_q.cfull};
                A_CDATA:  rd_word = s_q.cdata;
                default:  rd_word = wp_any;
            endcase
        end
    end

    assign cap_word = {{(CHAIN_W-DATA_W){1'b0}}, rd_word};

    always_comb begin
        s_d = s_q;
        if (capture_en && s_q.pend_valid && s_q.pend_addr == A_CDATA) begin
            s_d.cfull = 1'b0;
        end
        if (upd_rd) begin
            s_d.pend_valid = 1'b1;
            s_d.pend_addr  = wr_addr;
        end
        if (upd_wr) begin
            s_d.pend_valid = 1'b0;
            case (wr_addr)
                A_CTRL:   s_d.ctrl   = wr_data[CTRL_W-1:0];
                A_VCATCH: s_d.vcatch = wr_data[VCATCH_W-1:0];
                A_CCTRL:  s_d.ccfg   = wr_data[CCTRL_W-1:1];
                A_CDATA: begin
                    s_d.cdata = wr_data;
                    s_d.cfull = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign mon_mode = s_q.ctrl[MON_BIT];

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({capture_en, shift_en, update_en})); // R1
    AST_MON_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (upd_wr && wr_addr == A_CTRL) |=> (mon_mode == $past(wr_data[MON_BIT]))); // R7
    AST_READ_SCAN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        upd_rd |=> ($stable(s_q.ctrl) && $stable(s_q.vcatch) && $stable(s_q.cdata))); // R3
    AST_IDLE_CAPTURE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (capture_en && !s_q.pend_valid) |=> (chain_q == '0)); // R4
    AST_CAPTURE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> (chain_q[CHAIN_W-1:DATA_W] == '0)); // R3
    AST_COMMS_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_wr && wr_addr == A_CDATA) |=> s_q.cfull); // R10
    AST_COMMS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (capture_en && s_q.pend_valid && s_q.pend_addr == A_CDATA) |=> !s_q.cfull); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (capture_en && s_q.pend_valid && (s_q.pend_addr == 5'd3 || s_q.pend_addr >= 5'd22))
        |=> (chain_q == '0)); // R9
endmodule

// File: tb/dbg_scan_regs_tb.sv
module dbg_scan_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tdi = 1'b0;
    logic       capture_en = 1'b0;
    logic       shift_en = 1'b0;
    logic       update_en = 1'b0;
    logic [4:0] status_in = 5'h15;
    logic       tdo;
    logic       mon_mode;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [37:0] last_got;
    event        scan_done;

    always #5 clk = ~clk;

    dbg_scan_regs u_dut (
        .clk        (clk),
        .rst        (rst),
        .tdi        (tdi),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .status_in  (status_in),
        .tdo        (tdo),
        .mon_mode   (mon_mode)
    );

    task automatic check(input logic ok, input string tag, input logic [37:0] act, input logic [37:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Scan: capture, 38 shifts (LSB first, R1), update. Starts and ends at a negedge.
    task automatic scan(input logic dir, input logic [4:0] a, input logic [31:0] d,
                        input logic [31:0] expect_cap, input string tag);
        logic [37:0] word;
        logic [37:0] got;
        word = {dir, a, d};
        exp_q.push_back(expect_cap);
        tag_q.push_back(tag);
        capture_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0;
        for (int i = 0; i < 38; i++) begin
            got[i]   = tdo;
            tdi      = word[i];
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en  = 1'b0;
        update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
        last_got  = got;
        -> scan_done;
    endtask

    initial begin
        forever begin
            logic [31:0] v;
            string t;
            @(scan_done);
            v = exp_q.pop_front();
            t = tag_q.pop_front();
            check(last_got === {6'b0, v}, t, last_got, {6'b0, v});
        end
    end

    initial begin
        #(10 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    localparam logic W = 1'b1;
    localparam logic R = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(mon_mode === 1'b0, "R11 mon_mode after reset", 38'(mon_mode), 38'd0);

        scan(W, 5'd0, 32'hFFFF_FFFF, 32'h0, "R4 capture after reset");
        check(mon_mode === 1'b1, "R7 mon_mode set", 38'(mon_mode), 38'd1);
        scan(R, 5'd0, 32'h0, 32'h0, "R4 capture after write scan");
        scan(R, 5'd1, 32'h0, 32'h3F, "R5 debug control 6 bits");
        scan(W, 5'd1, 32'hFFFF_FFFF, 32'h15, "R6 status read");
        scan(R, 5'd1, 32'h0, 32'h0, "R4 after write");
        scan(W, 5'd0, 32'h0000_000F, 32'h15, "R6 status write ignored");
        check(mon_mode === 1'b0, "R7 mon_mode clear", 38'(mon_mode), 38'd0);

        scan(W, 5'd2, 32'hABCD_1234, 32'h0, "R2 write vector catch");
        scan(R, 5'd2, 32'hFFFF_0000, 32'h0, "R4");
        scan(R, 5'd0, 32'hF0F0_F0F0, 32'h34, "R5 vector catch 8 bits");
        scan(R, 5'd8, 32'hFFFF_FFFF, 32'h0F, "R3 read scan data ignored");
        scan(W, 5'd8, 32'h1111_1111, 32'h0, "R8 watch 0 reset value");
        scan(W, 5'd13, 32'hFFFF_FFFF, 32'h0, "R4");
        scan(W, 5'd12, 32'hFFFF_FFFF, 32'h0, "R4");
        scan(W, 5'd16, 32'hDEAD_BEEF, 32'h0, "R4");
        scan(W, 5'd21, 32'h1234_5678, 32'h0, "R4");
        scan(W, 5'd11, 32'hA5A5_A5A5, 32'h0, "R4");
        scan(W, 5'd3, 32'hFFFF_FFFF, 32'h0, "R4");
        scan(W, 5'd22, 32'hFFFF_FFFF, 32'h0, "R4");
        scan(W, 5'd31, 32'hFFFF_FFFF, 32'h0, "R4");
        scan(W, 5'd14, 32'hFFFF_FFFF, 32'h0, "R4");
        scan(R, 5'd8, 32'h0, 32'h0, "R4");
        scan(R, 5'd13, 32'h0, 32'h1111_1111, "R8 watch 0 addr value");
        scan(R, 5'd12, 32'h0, 32'hFF, "R8 control mask 8 bits");
        scan(R, 5'd16, 32'h0, 32'h1FF, "R8 control value 9 bits");
        scan(R, 5'd21, 32'h0, 32'hDEAD_BEEF, "R1 R8 watch 1 addr value");
        scan(R, 5'd11, 32'h0, 32'h78, "R8 watch 1 control mask");
        scan(R, 5'd3, 32'h0, 32'hA5A5_A5A5, "R8 watch 0 data mask");
        scan(R, 5'd22, 32'h0, 32'h0, "R9 address 3");
        scan(R, 5'd31, 32'h0, 32'h0, "R9 address 22");
        scan(R, 5'd14, 32'h0, 32'h0, "R9 address 31");
        scan(R, 5'd15, 32'hFFFF_FFFF, 32'h0, "R9 address 14");
        scan(R, 5'd4, 32'h0, 32'h0, "R9 address 15");

        scan(W, 5'd4, 32'hFFFF_FFFF, 32'h0, "R10 comms control reset");
        scan(R, 5'd4, 32'h0, 32'h0, "R4");
        scan(W, 5'd5, 32'hCAFE_F00D, 32'h3E, "R10 flag bit not writable");
        scan(R, 5'd4, 32'h0, 32'h0, "R4");
        scan(R, 5'd4, 32'h0, 32'h3F, "R10 full flag set");
        scan(R, 5'd5, 32'h0, 32'h3F, "R10 control read no side effect");
        scan(R, 5'd4, 32'h0, 32'hCAFE_F00D, "R10 comms data read");
        scan(R, 5'd0, 32'h0, 32'h3E, "R10 flag consumed");
        scan(W, 5'd5, 32'h0BAD_BEEF, 32'h0F, "R2 debug control held");
        scan(R, 5'd5, 32'h0, 32'h0, "R4");
        scan(R, 5'd5, 32'h0, 32'h0BAD_BEEF, "R10 first data read");
        scan(R, 5'd4, 32'h0, 32'h0BAD_BEEF, "R10 second data read keeps value");
        scan(W, 5'd0, 32'h0000_0010, 32'h3E, "R10 flag clear after double read");
        check(mon_mode === 1'b1, "R7 bit 4 alone", 38'(mon_mode), 38'd1);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(mon_mode === 1'b0, "R11 mon_mode cleared", 38'(mon_mode), 38'd0);
        scan(R, 5'd0, 32'h0, 32'h0, "R11 no pending after reset");
        scan(R, 5'd8, 32'h0, 32'h0, "R11 debug control cleared");
        scan(R, 5'd5, 32'h0, 32'h0, "R11 watch register cleared");
        scan(R, 5'd4, 32'h0, 32'h0, "R11 comms data cleared");
        scan(R, 5'd0, 32'h0, 32'h0, "R11 comms control cleared");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule